// File: doc/BRIEF.md
# Serial Access Row Buffer

This block pairs a word-addressed storage array, modelled as a DRAM-like memory with a random-access port, with a 256-entry by 16-bit serial buffer. A transfer command takes one half of one array row, 256 of its 512 columns, and copies it into the serial buffer in a single clock cycle. The buffer then drains one word per serial advance on a 16-bit output, with one output bit for each bit plane.

Once a transfer has completed, the random-access port and the serial side do not affect each other. The array can be read and written while the buffer streams, and those accesses never change words that are already in the buffer. A display pipeline uses this arrangement in the following way. Pixels are stored at one 16-bit pixel per word in scanline order, 512 pixels to a row. Each transfer then hands the video path half a scanline, while drawing traffic continues to use the random-access port.

Top module: `sab_top`

## Requirements
- R1: After reset, sdq and ra_rdata are 0 and sdq_valid is 0. Before the first transfer, raising sclk_en produces no valid output.
- R2: A transfer fills the serial buffer in the clock edge that samples xfer_req. Entry i receives the array word at address {xfer_row, xfer_half, i}: half 0 supplies columns 0 to 255 and half 1 supplies columns 256 to 511. With a start tap of 0, entry i is therefore pixel xfer_row*512 + xfer_half*256 + i in scanline order.
- R3: The first advance after a transfer outputs the entry at xfer_tap. Each later advance outputs the next higher entry.
- R4: The serial position wraps from entry 255 to entry 0.
- R5: An advance happens on a clock edge where sclk_en is 1, a transfer has happened since reset, and xfer_req is 0. sdq_valid is 1 in the cycle after each advance and 0 otherwise. sdq holds its value when there is no advance.
- R6: A transfer issued during streaming replaces every buffer entry and restarts at the new tap. A transfer takes priority over an advance requested in the same cycle.
- R7: On a random-access read (ra_en=1, ra_we=0), ra_rdata shows the addressed word from the cycle after the read onward. A write (ra_en=1, ra_we=1) stores ra_wdata at {ra_row, ra_col}. ra_rdata does not change without a read.
- R8: Random-access writes issued after a transfer, including writes to the row that was transferred, do not change the words that the buffer later outputs.
- R9: A transfer issued in the same cycle as a write to the transferred half captures the data as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_en | input | 1 | Random-access request |
| ra_we | input | 1 | Write when 1, read when 0 |
| ra_row | input | 2 | Random-access row |
| ra_col | input | 9 | Random-access column |
| ra_wdata | input | 16 | Write data |
| ra_rdata | output | 16 | Registered read data |
| xfer_req | input | 1 | Load serial buffer from the array |
| xfer_row | input | 2 | Row to transfer |
| xfer_half | input | 1 | Row half: 0 lower, 1 upper |
| xfer_tap | input | 8 | First entry to stream |
| sclk_en | input | 1 | Serial advance enable |
| sdq | output | 16 | Serial output word |
| sdq_valid | output | 1 | sdq updated by the previous edge |

## Verification
The assertions assume that every control input is driven to a known 0 or 1 during reset and at each sampled edge. They also assume that reset is held low for at least one edge before the first command, because the history checks compare against the reset values. The bench drives every input from tasks on the falling clock edge. It never leaves a control input undriven, and it asserts reset with all inputs at zero. Random traffic sets the addresses and the tap with full-range $urandom values, so every draw is a legal encoding.

// File: rtl/sab_pkg.sv
package sab_pkg;
    parameter int SAB_WORD_W = 16;
    parameter int SAB_DEPTH  = 256;
    localparam int SAB_PTR_W = $clog2(SAB_DEPTH);
    localparam int SAB_COL_W = SAB_PTR_W + 1;

    typedef logic [SAB_WORD_W-1:0] word_t;
    typedef logic [SAB_PTR_W-1:0]  ptr_t;
    typedef word_t [SAB_DEPTH-1:0] half_row_t;

    typedef struct packed {
        ptr_t ptr;
        logic loaded;
    } ctr_state_t;

    typedef struct packed {
        word_t sdq;
        logic  valid;
    } out_state_t;
endpackage

// File: rtl/sab_array.sv
module sab_array
    import sab_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ra_en,
    input  logic                      ra_we,
    input  logic [$clog2(ROWS)-1:0]   ra_row,
    input  logic [SAB_COL_W-1:0]      ra_col,
    input  word_t                     ra_wdata,
    output word_t                     ra_rdata,
    input  logic [$clog2(ROWS)-1:0]   xfer_row,
    input  logic                      xfer_half,
    output half_row_t                 half_o
);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int ADDR_W = ROW_W + SAB_COL_W;
    localparam int WORDS  = 1 << ADDR_W;

    typedef struct packed {
        word_t [WORDS-1:0] mem;
        word_t             rdata;
    } arr_state_t;

    arr_state_t st_d, st_q;
    logic [ADDR_W-1:0] ra_addr;

    assign ra_addr = {ra_row, ra_col};

    always_comb begin
        st_d = st_q;
        if (ra_en) begin
            if (ra_we) begin
                st_d.mem[ra_addr] = ra_wdata;
            end else begin
                st_d.rdata = st_q.mem[ra_addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Parallel read of one half row, taken from the state before this edge's write
    for (genvar g = 0; g < SAB_DEPTH; g++) begin : g_tap
        localparam ptr_t TAP = SAB_PTR_W'(g);
        assign half_o[g] = st_q.mem[{xfer_row, xfer_half, TAP}];
    end

    assign ra_rdata = st_q.rdata;
endmodule

// File: rtl/sab_rowbuf.sv
module sab_rowbuf
    import sab_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  half_row_t din,
    input  ptr_t      rd_idx,
    output word_t     dout
);
    half_row_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (load) begin
            buf_d = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign dout = buf_q[rd_idx];
endmodule

// File: rtl/sab_serial_ctr.sv
module sab_serial_ctr
    import sab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer,
    input  ptr_t tap,
    input  logic step_req,
    output ptr_t ptr,
    output logic adv
);
    ctr_state_t st_d, st_q;
    logic       adv_c;

    always_comb begin
        st_d  = st_q;
        adv_c = step_req && st_q.loaded && !xfer;
        if (xfer) begin
            st_d.ptr    = tap;
            st_d.loaded = 1'b1;
        end else if (adv_c) begin
            st_d.ptr = st_q.ptr + SAB_PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;
    assign adv = adv_c;
endmodule

// File: rtl/sab_top.sv
module sab_top
    import sab_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ra_en,
    input  logic                    ra_we,
    input  logic [$clog2(ROWS)-1:0] ra_row,
    input  logic [SAB_COL_W-1:0]    ra_col,
    input  logic [SAB_WORD_W-1:0]   ra_wdata,
    output logic [SAB_WORD_W-1:0]   ra_rdata,
    input  logic                    xfer_req,
    input  logic [$clog2(ROWS)-1:0] xfer_row,
    input  logic                    xfer_half,
    input  logic [SAB_PTR_W-1:0]    xfer_tap,
    input  logic                    sclk_en,
    output logic [SAB_WORD_W-1:0]   sdq,
    output logic                    sdq_valid
);
    half_row_t  half_words;
    ptr_t       srl_ptr;
    logic       srl_adv;
    word_t      buf_word;
    out_state_t out_d, out_q;

    sab_array #(.ROWS(ROWS)) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .ra_en     (ra_en),
        .ra_we     (ra_we),
        .ra_row    (ra_row),
        .ra_col    (ra_col),
        .ra_wdata  (ra_wdata),
        .ra_rdata  (ra_rdata),
        .xfer_row  (xfer_row),
        .xfer_half (xfer_half),
        .half_o    (half_words)
    );

    sab_rowbuf i_rowbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (xfer_req),
        .din    (half_words),
        .rd_idx (srl_ptr),
        .dout   (buf_word)
    );

    sab_serial_ctr i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer     (xfer_req),
        .tap      (xfer_tap),
        .step_req (sclk_en),
        .ptr      (srl_ptr),
        .adv      (srl_adv)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = srl_adv;
        if (srl_adv) begin
            out_d.sdq = buf_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sdq       = out_q.sdq;
    assign sdq_valid = out_q.valid;
endmodule

// File: rtl/sab_checker.sv
module sab_checker #(
    parameter int PTR_W  = 8,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ra_en,
    input logic              ra_we,
    input logic [WORD_W-1:0] ra_rdata,
    input logic              xfer_req,
    input logic [PTR_W-1:0]  xfer_tap,
    input logic              sclk_en,
    input logic [WORD_W-1:0] sdq,
    input logic              sdq_valid,
    input logic [PTR_W-1:0]  ptr,
    input logic              adv
);
    a_r5_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sdq_valid |-> $past(sclk_en));

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sdq_valid |-> $stable(sdq));

    a_r5_valid_after_adv: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> sdq_valid);

    a_r6_xfer_wins: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !sdq_valid);

    a_r6_tap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> (ptr == $past(xfer_tap)));

    a_r4_ptr_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (ptr == $past(ptr) + PTR_W'(1)));

    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ra_en && !ra_we) |=> $stable(ra_rdata));
endmodule

bind sab_top sab_checker #(.PTR_W(sab_pkg::SAB_PTR_W), .WORD_W(sab_pkg::SAB_WORD_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ra_en     (ra_en),
    .ra_we     (ra_we),
    .ra_rdata  (ra_rdata),
    .xfer_req  (xfer_req),
    .xfer_tap  (xfer_tap),
    .sclk_en   (sclk_en),
    .sdq       (sdq),
    .sdq_valid (sdq_valid),
    .ptr       (srl_ptr),
    .adv       (srl_adv)
);

// File: tb/test_sab_top.sv
module test_sab_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ra_en = 1'b0, ra_we = 1'b0;
    logic [1:0]  ra_row = '0;
    logic [8:0]  ra_col = '0;
    logic [15:0] ra_wdata = '0;
    logic [15:0] ra_rdata;
    logic        xfer_req = 1'b0;
    logic [1:0]  xfer_row = '0;
    logic        xfer_half = 1'b0;
    logic [7:0]  xfer_tap = '0;
    logic        sclk_en = 1'b0;
    logic [15:0] sdq;
    logic        sdq_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag = "R1";

    logic [15:0] mem_m [0:2047];
    logic [15:0] buf_m [0:255];
    logic [7:0]  ptr_m = '0;
    bit          loaded_m = 1'b0;
    logic [15:0] exp_sdq = '0;
    bit          exp_valid = 1'b0;
    logic [15:0] exp_rdata = '0;

    always #5 clk = ~clk;

    sab_top i_sab_top (
        .clk(clk), .rst_n(rst_n), .ra_en(ra_en), .ra_we(ra_we), .ra_row(ra_row),
        .ra_col(ra_col), .ra_wdata(ra_wdata), .ra_rdata(ra_rdata), .xfer_req(xfer_req),
        .xfer_row(xfer_row), .xfer_half(xfer_half), .xfer_tap(xfer_tap),
        .sclk_en(sclk_en), .sdq(sdq), .sdq_valid(sdq_valid)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h9E37) ^ 16'h5A5A);
    endfunction

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update model at the rising edge, compare after it
    task automatic step(input bit en, input bit we, input logic [1:0] row, input logic [8:0] col,
                        input logic [15:0] wd, input bit xr, input logic [1:0] xrow,
                        input bit xh, input logic [7:0] xtap, input bit sce);
        bit rd;
        ra_en = en; ra_we = we; ra_row = row; ra_col = col; ra_wdata = wd;
        xfer_req = xr; xfer_row = xrow; xfer_half = xh; xfer_tap = xtap; sclk_en = sce;
        @(posedge clk);
        rd = en && !we;
        if (rd) exp_rdata = mem_m[{row, col}];
        if (xr) begin
            for (int i = 0; i < 256; i++) buf_m[i] = mem_m[{xrow, xh, 8'(i)}];
            ptr_m = xtap;
            loaded_m = 1'b1;
            exp_valid = 1'b0;
        end else if (sce && loaded_m) begin
            exp_sdq = buf_m[ptr_m];
            ptr_m = ptr_m + 8'd1;
            exp_valid = 1'b1;
        end else begin
            exp_valid = 1'b0;
        end
        if (en && we) mem_m[{row, col}] = wd;
        #2;
        chk({tag, " valid"}, 32'(sdq_valid), 32'(exp_valid));
        if (exp_valid) chk({tag, " sdq"}, 32'(sdq), 32'(exp_sdq));
        if (rd) chk("R7 rdata", 32'(ra_rdata), 32'(exp_rdata));
        @(negedge clk);
    endtask

    task automatic idle(input bit sce);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, sce);
    endtask

    task automatic xfer(input logic [1:0] r, input bit h, input logic [7:0] t, input bit sce);
        step(0, 0, 0, 0, 0, 1, r, h, t, sce);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'd4242);
        for (int i = 0; i < 2048; i++) mem_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset sdq", 32'(sdq), 0);
        chk("R1 reset valid", 32'(sdq_valid), 0);
        chk("R1 reset rdata", 32'(ra_rdata), 0);
        rst_n = 1'b1;
        tag = "R1";
        repeat (3) idle(1);

        // Fill the array through the random-access port
        tag = "R7";
        for (int a = 0; a < 2048; a++) step(1, 1, 2'(a >> 9), 9'(a), pat(a), 0, 0, 0, 0, 0);
        for (int a = 0; a < 2048; a += 97) step(1, 0, 2'(a >> 9), 9'(a), 0, 0, 0, 0, 0, 0);

        // Upper half of row 1 from tap 0, in scanline order
        tag = "R2";
        xfer(1, 1, 0, 0);
        for (int i = 0; i < 256; i++) begin
            idle(1);
            chk("R2 scanline pixel", 32'(sdq), 32'(pat(512 + 256 + i)));
        end
        tag = "R3";
        xfer(2, 0, 8'd10, 0);
        repeat (5) idle(1);
        chk("R3 ascending from tap", 32'(sdq), 32'(pat(1024 + 14)));

        // Wrap from the top entry
        tag = "R4";
        xfer(3, 1, 8'd253, 0);
        repeat (5) idle(1);
        chk("R4 wrapped to entry 1", 32'(sdq), 32'(pat(1536 + 256 + 1)));

        // Enable gaps
        tag = "R5";
        for (int i = 0; i < 20; i++) idle(i % 3 == 0);

        // Transfer mid-stream and transfer with simultaneous advance
        tag = "R6";
        xfer(0, 0, 8'd100, 0);
        repeat (3) idle(1);
        xfer(0, 1, 8'd7, 1);
        idle(1);
        chk("R6 restart at new tap", 32'(sdq), 32'(pat(256 + 7)));

        // Writes to the transferred row while streaming
        tag = "R8";
        xfer(2, 1, 0, 0);
        for (int i = 0; i < 256; i++) step(1, 1, 2, 9'(256 + ((i + 5) % 256)), 16'hDEAD, 0, 0, 0, 0, 1);
        chk("R8 last word unchanged", 32'(sdq), 32'(pat(1024 + 511)));

        // Same-cycle write and transfer of the same half
        tag = "R9";
        step(1, 1, 3, 9'd4, 16'hBEEF, 1, 3, 0, 8'd4, 0);
        idle(1);
        chk("R9 pre-write data", 32'(sdq), 32'(pat(1536 + 4)));

        // Random traffic
        tag = "R5";
        for (int n = 0; n < 6000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[1], 2'($urandom), 9'($urandom), 16'($urandom),
                 ($urandom % 40) == 0, 2'($urandom), r[2], 8'($urandom), (r[7:4] < 11));
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule